// File: doc/BRIEF.md
# Filtered Multi-Counter Event Monitor

This block is a bank of event counters placed beside a PCIe root complex. Every counter owns a selection word naming an event code, a subevent code, a root port and a function number. Each cycle the root complex may present one event record carrying those four fields plus an increment amount. Every counter whose selection matches all four fields adds the increment, provided the global run bit is set.

Software reaches the bank through a plain register port: a write strobe with address and data, and a combinational read data bus. Counters are 48 bits wide and may be preloaded, so a counter started near the top of its range overflows after a chosen number of events. A carry out of the top bit sets a sticky per-counter status bit. Status bits are cleared by writing ones to a separate clear register. A mask register gates each status bit onto a single shared interrupt line. A read-only bitmap tells software which root ports this monitor serves.

Top module: `rc_evmon`

## Requirements
- R1: After reset all counters, selection words, status bits and the run bit are zero, every mask bit is one (masked), and `irq` is low.
- R2: Bit 0 of the register at 0x00 is the run bit. While it is zero, no event record changes any counter.
- R3: The counter i value is at 0x80+8*i. A write loads bits [47:0] and a read returns the value zero-extended to 64 bits. A load and a matching event in the same cycle leave the loaded value.
- R4: The selection word of counter i is at 0x40+8*i. It holds the event code in [7:0], the root port in [12:8], the function in [23:16] and the subevent in [47:32]. All other bits read as zero.
- R5: With the run bit set and a non-zero selection word, a valid event whose code, subevent, port and function all equal the selection adds `ev_inc` to the counter, visible on the next cycle. A mismatch in any field, or an all-zero selection word, leaves the counter unchanged.
- R6: A carry out of bit 47 wraps the counter modulo 2^48 and sets status bit i (register 0x08). The bit stays set until a one is written to bit i of the clear register at 0x10; an overflow in the same cycle as its clear leaves it set. Writes to 0x08 have no effect.
- R7: Mask bit i sits in the register at 0x18, where 1 masks and 0 enables. `irq` is high exactly when some status bit is set with its mask bit zero.
- R8: The register at 0x20 reads the served-port bitmap (default 0x000F00FF, bit n for port n, ports 0 to 0x13) and ignores writes.
- R9: The clear register, misaligned addresses and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| ev_valid | input | 1 | Event record present this cycle |
| ev_code | input | 8 | Event code |
| ev_sub | input | 16 | Subevent code |
| ev_port | input | 5 | Root port number |
| ev_func | input | 8 | Function number |
| ev_inc | input | 16 | Increment amount |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The hardest case to reach is a carry out of a 48-bit counter, because small increments would need about 2^48 events to get there. The bench reaches it by preloading counters a few counts below the wrap point and then sending matching events. It does this in directed steps and also in the random phase. Directed steps also line up an overflow with a clear of the same status bit, and a preload with a matching event. Doing each in one cycle checks both same-cycle priority rules.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 64;
    localparam int EVT_W  = 8;
    localparam int PORT_W = 5;
    localparam int FUNC_W = 8;
    localparam int SUB_W  = 16;

    // Selection-word field positions (decoded by software tooling)
    localparam int EVT_LSB  = 0;
    localparam int PORT_LSB = 8;
    localparam int FUNC_LSB = 16;
    localparam int SUB_LSB  = 32;

    // Region code in reg_addr[7:6], slot in reg_addr[5:3]
    localparam logic [1:0] RGN_GLOBAL = 2'b00;
    localparam logic [1:0] RGN_SELECT = 2'b01;
    localparam logic [1:0] RGN_COUNT  = 2'b10;

    localparam logic [2:0] SLOT_RUN   = 3'd0;
    localparam logic [2:0] SLOT_STAT  = 3'd1;
    localparam logic [2:0] SLOT_CLEAR = 3'd2;
    localparam logic [2:0] SLOT_MASK  = 3'd3;
    localparam logic [2:0] SLOT_PMAP  = 3'd4;

    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [FUNC_W-1:0] func;
        logic [PORT_W-1:0] port;
        logic [EVT_W-1:0]  code;
    } sel_t;

    function automatic sel_t sel_unpack(input logic [DATA_W-1:0] w);
        sel_t s;
        s.code = w[EVT_LSB  +: EVT_W];
        s.port = w[PORT_LSB +: PORT_W];
        s.func = w[FUNC_LSB +: FUNC_W];
        s.sub  = w[SUB_LSB  +: SUB_W];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] sel_pack(input sel_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EVT_LSB  +: EVT_W]  = s.code;
        w[PORT_LSB +: PORT_W] = s.port;
        w[FUNC_LSB +: FUNC_W] = s.func;
        w[SUB_LSB  +: SUB_W]  = s.sub;
        return w;
    endfunction
endpackage

// File: rtl/evmon_filter.sv
module evmon_filter
    import evmon_pkg::*;
(
    input  logic              run,
    input  sel_t              sel,
    input  logic              ev_valid,
    input  logic [EVT_W-1:0]  ev_code,
    input  logic [SUB_W-1:0]  ev_sub,
    input  logic [PORT_W-1:0] ev_port,
    input  logic [FUNC_W-1:0] ev_func,
    output logic              hit
);
    logic armed;
    logic fields_eq;

    always_comb begin
        armed     = run && ev_valid && (sel != '0);
        fields_eq = (sel.code == ev_code) && (sel.sub == ev_sub) &&
                    (sel.port == ev_port) && (sel.func == ev_func);
        hit       = armed && fields_eq;
    end
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             add,
    input  logic [INC_W-1:0] add_val,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);
    localparam int PAD_W = CNT_W + 1 - INC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum   = {1'b0, cnt_q.cnt} + {{PAD_W{1'b0}}, add_val};
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (add) begin
            cnt_d.cnt = sum[CNT_W-1:0];
            wrap      = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q.cnt;
endmodule

// File: rtl/rc_evmon.sv
module rc_evmon
    import evmon_pkg::*;
#(
    parameter int          N_CNT    = 4,
    parameter int          CNT_W    = 48,
    parameter int          INC_W    = 16,
    parameter int          N_PORTS  = 20,
    parameter logic [31:0] PORT_MAP = 32'h000F_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_valid,
    input  logic [EVT_W-1:0]  ev_code,
    input  logic [SUB_W-1:0]  ev_sub,
    input  logic [PORT_W-1:0] ev_port,
    input  logic [FUNC_W-1:0] ev_func,
    input  logic [INC_W-1:0]  ev_inc,
    output logic              irq
);
    localparam int          IDX_W     = $clog2(N_CNT);
    localparam logic [31:0] PORT_MASK = (N_PORTS >= 32) ? 32'hFFFF_FFFF
                                        : ((32'd1 << N_PORTS) - 32'd1);
    localparam logic [31:0] MAP_SEEN  = PORT_MAP & PORT_MASK;

    typedef struct packed {
        logic                 run;
        logic [N_CNT-1:0]     mask;
        logic [N_CNT-1:0]     status;
        sel_t [N_CNT-1:0]     sel;
    } bank_t;

    bank_t state_d, state_q;

    logic [1:0]            region;
    logic [2:0]            slot;
    logic                  aligned;
    logic                  slot_ok;
    logic [IDX_W-1:0]      idx;
    logic                  wr_global;
    logic                  wr_select;
    logic [N_CNT-1:0]      clr_bits;
    logic [N_CNT-1:0]      load_vec;
    logic [N_CNT-1:0]      hit_vec;
    logic [N_CNT-1:0]      wrap_vec;
    logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
    logic                  unused_wdata;

    // Address decode
    always_comb begin
        region    = reg_addr[7:6];
        slot      = reg_addr[5:3];
        aligned   = (reg_addr[2:0] == 3'd0);
        slot_ok   = ({29'd0, slot} < N_CNT);
        idx       = slot[IDX_W-1:0];
        wr_global = reg_wr && aligned && (region == RGN_GLOBAL);
        wr_select = reg_wr && aligned && (region == RGN_SELECT) && slot_ok;
        clr_bits  = (wr_global && slot == SLOT_CLEAR) ? reg_wdata[N_CNT-1:0] : '0;
    end

    assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

    // Per-counter filter and counter
    for (genvar i = 0; i < N_CNT; i++) begin : g_lane
        assign load_vec[i] = reg_wr && aligned && (region == RGN_COUNT) &&
                             (slot == 3'(i));

        evmon_filter u_filter (
            .run      (state_q.run),
            .sel      (state_q.sel[i]),
            .ev_valid (ev_valid),
            .ev_code  (ev_code),
            .ev_sub   (ev_sub),
            .ev_port  (ev_port),
            .ev_func  (ev_func),
            .hit      (hit_vec[i])
        );

        evmon_counter #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_vec[i]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .add      (hit_vec[i]),
            .add_val  (ev_inc),
            .value    (cnt_val[i]),
            .wrap     (wrap_vec[i])
        );
    end

    // Next-state for configuration and status
    always_comb begin
        state_d = state_q;
        if (wr_global) begin
            case (slot)
                SLOT_RUN:  state_d.run  = reg_wdata[0];
                SLOT_MASK: state_d.mask = reg_wdata[N_CNT-1:0];
                default:   ;
            endcase
        end
        if (wr_select) begin
            state_d.sel[idx] = sel_unpack(reg_wdata);
        end
        // A wrap in the same cycle as its clear wins
        state_d.status = (state_q.status & ~clr_bits) | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mask <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (region)
                RGN_GLOBAL: begin
                    case (slot)
                        SLOT_RUN:  reg_rdata[0]       = state_q.run;
                        SLOT_STAT: reg_rdata[N_CNT-1:0] = state_q.status;
                        SLOT_MASK: reg_rdata[N_CNT-1:0] = state_q.mask;
                        SLOT_PMAP: reg_rdata[31:0]    = MAP_SEEN;
                        default:   ;
                    endcase
                end
                RGN_SELECT: if (slot_ok) reg_rdata = sel_pack(state_q.sel[idx]);
                RGN_COUNT:  if (slot_ok) reg_rdata[CNT_W-1:0] = cnt_val[idx];
                default:    ;
            endcase
        end
    end

    assign irq = |(state_q.status & ~state_q.mask);
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
    parameter int N_CNT = 4,
    parameter int CNT_W = 48
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic [7:0]             reg_addr,
    input logic [CNT_W-1:0]       wdata,
    input logic                   run_q,
    input logic [N_CNT-1:0]       mask_q,
    input logic [N_CNT-1:0]       status_q,
    input logic [N_CNT*CNT_W-1:0] cnt_flat,
    input logic                   irq
);
    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reg_wr) |=> $stable(cnt_flat));

    assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h00) |=> (run_q == $past(wdata[0])));

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h18) |=> (mask_q == $past(wdata[N_CNT-1:0])));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status_q & ~mask_q) != '0));

    for (genvar i = 0; i < N_CNT; i++) begin : g_chk
        assert_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 8'(8'h80 + 8 * i))
            |=> (cnt_flat[i*CNT_W +: CNT_W] == $past(wdata)));

        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !(reg_wr && reg_addr == 8'h10 && wdata[i]))
            |=> status_q[i]);
    end
endmodule

bind rc_evmon evmon_checker #(
    .N_CNT (N_CNT),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata    (reg_wdata[CNT_W-1:0]),
    .run_q    (state_q.run),
    .mask_q   (state_q.mask),
    .status_q (state_q.status),
    .cnt_flat (cnt_val),
    .irq      (irq)
);

// File: tb/rc_evmon_tb.sv
module rc_evmon_tb;
    localparam int CLK_P = 10;
    localparam logic [63:0] SELMASK = 64'h0000_FFFF_00FF_1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic [15:0] ev_sub = '0;
    logic [4:0]  ev_port = '0;
    logic [7:0]  ev_func = '0;
    logic [15:0] ev_inc = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [47:0] m_cnt [4];
    logic [63:0] m_sel [4];
    logic        m_run;
    logic [3:0]  m_mask;
    logic [3:0]  m_stat;

    always #(CLK_P/2) clk = ~clk;

    rc_evmon u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_code(ev_code), .ev_sub(ev_sub), .ev_port(ev_port),
        .ev_func(ev_func), .ev_inc(ev_inc), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // Model of one clock edge, from the requirements
    task automatic model_edge(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                              input bit ev, input logic [7:0] c, input logic [15:0] s,
                              input logic [4:0] p, input logic [7:0] f, input logic [15:0] inc);
        logic [3:0] setb, clrb;
        logic [48:0] sum;
        bit hit;
        setb = '0;
        clrb = (wr && a == 8'h10) ? wd[3:0] : 4'h0;
        for (int i = 0; i < 4; i++) begin
            hit = ev && m_run && (m_sel[i] != 0) && (m_sel[i][7:0] == c) &&
                  (m_sel[i][12:8] == p) && (m_sel[i][23:16] == f) && (m_sel[i][47:32] == s);
            if (wr && a == 8'(8'h80 + 8*i)) m_cnt[i] = wd[47:0];
            else if (hit) begin
                sum = {1'b0, m_cnt[i]} + {33'd0, inc};
                m_cnt[i] = sum[47:0];
                if (sum[48]) setb[i] = 1'b1;
            end
        end
        if (wr && a == 8'h00) m_run = wd[0];
        if (wr && a == 8'h18) m_mask = wd[3:0];
        for (int i = 0; i < 4; i++)
            if (wr && a == 8'(8'h40 + 8*i)) m_sel[i] = wd & SELMASK;
        m_stat = (m_stat & ~clrb) | setb;
    endtask

    task automatic step(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                        input bit ev, input logic [7:0] c, input logic [15:0] s,
                        input logic [4:0] p, input logic [7:0] f, input logic [15:0] inc);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        ev_valid = ev; ev_code = c; ev_sub = s; ev_port = p; ev_func = f; ev_inc = inc;
        @(posedge clk);
        #1;
        model_edge(wr, a, wd, ev, c, s, p, f, inc);
        @(negedge clk);
        reg_wr = 1'b0; ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        step(1'b1, a, d, 1'b0, 8'd0, 16'd0, 5'd0, 8'd0, 16'd0);
    endtask

    task automatic evt(input logic [7:0] c, input logic [15:0] s, input logic [4:0] p,
                       input logic [7:0] f, input logic [15:0] inc);
        step(1'b0, 8'h00, 64'd0, 1'b1, c, s, p, f, inc);
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [63:0] d;
        rd(8'h00, d); check({tag, " R2 run"}, d, {63'd0, m_run});
        rd(8'h08, d); check({tag, " R6 status"}, d, {60'd0, m_stat});
        rd(8'h18, d); check({tag, " R7 mask"}, d, {60'd0, m_mask});
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h40 + 8*i), d); check({tag, " R4 select"}, d, m_sel[i]);
            rd(8'(8'h80 + 8*i), d); check({tag, " R3 count"}, d, {16'd0, m_cnt[i]});
        end
        check({tag, " R7 irq"}, {63'd0, irq}, {63'd0, |(m_stat & ~m_mask)});
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog R1 to end: actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [63:0] w0;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
        m_run = 1'b0; m_mask = 4'hF; m_stat = 4'h0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check_all("R1");
        check("R1 irq low", {63'd0, irq}, 64'd0);

        // R8 port bitmap, read-only
        rd(8'h20, d); check("R8 bitmap", d, 64'h0000_0000_000F_00FF);
        wr(8'h20, '1);
        rd(8'h20, d); check("R8 write ignored", d, 64'h0000_0000_000F_00FF);

        // R9 reads of clear, misaligned and unmapped addresses
        wr(8'h10, 64'hF);
        rd(8'h10, d); check("R9 clear reads zero", d, 64'd0);
        rd(8'hC0, d); check("R9 unmapped", d, 64'd0);
        wr(8'h40, '1);
        rd(8'h44, d); check("R9 misaligned", d, 64'd0);

        // R4 field masking on readback
        rd(8'h40, d); check("R4 unused bits zero", d, SELMASK);

        // Program counter 0: code 5, port 3, func 2, subevent 0x77
        w0 = 64'h0000_0077_0002_0305;
        wr(8'h40, w0);
        rd(8'h40, d); check("R4 select readback", d, w0);

        // R2 run off: matching event ignored
        evt(8'd5, 16'h77, 5'd3, 8'd2, 16'd10);
        rd(8'h80, d); check("R2 no count while stopped", d, 64'd0);

        wr(8'h00, 64'd1);
        evt(8'd5, 16'h77, 5'd3, 8'd2, 16'd10);
        rd(8'h80, d); check("R5 match adds", d, 64'd10);
        evt(8'd6, 16'h77, 5'd3, 8'd2, 16'd10);
        evt(8'd5, 16'h78, 5'd3, 8'd2, 16'd10);
        evt(8'd5, 16'h77, 5'd4, 8'd2, 16'd10);
        evt(8'd5, 16'h77, 5'd3, 8'd1, 16'd10);
        rd(8'h80, d); check("R5 any field mismatch ignored", d, 64'd10);
        evt(8'd0, 16'h0, 5'd0, 8'd0, 16'd7);
        rd(8'h88, d); check("R5 zero select ignored", d, 64'd0);

        // R3 load beats same-cycle event
        step(1'b1, 8'h80, 64'd100, 1'b1, 8'd5, 16'h77, 5'd3, 8'd2, 16'd9);
        rd(8'h80, d); check("R3 load priority", d, 64'd100);
        wr(8'h80, 64'hFFFF_0000_0000_0042);
        rd(8'h80, d); check("R3 upper bits dropped", d, 64'h42);

        // R6 / R7 overflow, mask, clear
        wr(8'h80, 64'h0000_FFFF_FFFF_FFFD);
        evt(8'd5, 16'h77, 5'd3, 8'd2, 16'd5);
        rd(8'h80, d); check("R6 wrap value", d, 64'd2);
        rd(8'h08, d); check("R6 status set", d, 64'd1);
        check("R7 masked irq", {63'd0, irq}, 64'd0);
        wr(8'h18, 64'hE);
        check("R7 unmasked irq", {63'd0, irq}, 64'd1);
        evt(8'd5, 16'h77, 5'd3, 8'd2, 16'd1);
        rd(8'h08, d); check("R6 sticky", d, 64'd1);
        wr(8'h08, 64'd0);
        rd(8'h08, d); check("R6 status write ignored", d, 64'd1);
        wr(8'h10, 64'd1);
        rd(8'h08, d); check("R6 cleared", d, 64'd0);
        check("R7 irq drops", {63'd0, irq}, 64'd0);
        wr(8'h80, 64'h0000_FFFF_FFFF_FFFF);
        step(1'b1, 8'h10, 64'd1, 1'b1, 8'd5, 16'h77, 5'd3, 8'd2, 16'd1);
        rd(8'h08, d); check("R6 set beats clear", d, 64'd1);
        check_all("directed");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic [63:0] sw;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                sw = '0;
                sw[7:0]   = 8'($urandom_range(1, 2));
                sw[12:8]  = 5'($urandom_range(0, 3));
                sw[23:16] = 8'($urandom_range(0, 1));
                sw[47:32] = 16'($urandom_range(0, 1) * 3);
                sw[63:48] = 16'($urandom);
                wr(8'(8'h40 + 8 * $urandom_range(0, 3)), sw);
            end else if (r < 14) begin
                wr(8'(8'h80 + 8 * $urandom_range(0, 3)),
                   {16'd0, 32'hFFFF_FFFF, 16'($urandom_range(16'hF000, 16'hFFFF))});
            end else if (r < 17) begin
                wr(8'h18, 64'($urandom_range(0, 15)));
            end else if (r < 20) begin
                wr(8'h10, 64'($urandom_range(0, 15)));
            end else if (r < 22) begin
                wr(8'h00, 64'($urandom_range(0, 9) != 0));
            end else begin
                step(($urandom_range(0, 9) == 0), 8'h10, 64'($urandom_range(0, 15)), 1'b1,
                     8'($urandom_range(1, 2)), 16'($urandom_range(0, 1) * 3),
                     5'($urandom_range(0, 3)), 8'($urandom_range(0, 1)),
                     16'($urandom_range(0, 4000)));
            end
            if (n % 25 == 24) check_all("R5 random");
        end
        check_all("R6 random end");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule